// File: doc/BRIEF.md
# NAND Command and Address Sequencer

This block sends one page-operation sequence to a NAND flash device. A single request makes it send a leading command byte, four address bytes in turn, and a closing command byte. Each byte goes out as a complete write-enable cycle made of a setup part, a low part and a hold part, with the chip enable held low the whole time. Every byte uses the general timing set, except the closing command byte. That byte uses a separate set whose longer hold covers the time the device needs after the last write-enable rise before it pulls its ready/busy line low.

After the closing command, the block watches the ready/busy line. It waits for the line to go low and then for it to return high, and then raises a one-clock completion pulse. If the line never goes low within a programmable number of cycles, the completion pulse carries a timeout flag instead. Some devices drop an operation when chip enable rises too early. For those, a mode input keeps chip enable low through the whole watch. Without the mode, chip enable rises as soon as the closing byte's hold ends. All request values are captured when the request is accepted, so the caller may change them afterwards.

Top module: `nand_seq_ctrl`

## Requirements
- R1: Out of reset the block is idle: `ce_n`=1, `we_n`=1, `cle`=0, `ale`=0, `dq`=0, `busy`=0, `done`=0, `timeout`=0.
- R2: After an accepted start, `dq` carries, in this order, `cmd_first`, `row_col_addr[7:0]`, `row_col_addr[15:8]`, `row_col_addr[23:16]`, `row_col_addr[31:24]`, `cmd_second`, with no gap cycles between bytes. Outside byte cycles `dq` is 0.
- R3: `cle` is 1 exactly during the two command byte cycles and `ale` is 1 exactly during the four address byte cycles. The two are never 1 together.
- R4: Each of the first five byte cycles lasts `com_setup` cycles with `we_n`=1, then `com_low` cycles with `we_n`=0, then `com_hold` cycles with `we_n`=1, all with `ce_n`=0. The first byte cycle begins in the clock after the start is sampled.
- R5: The closing command byte uses `att_setup`, `att_low` and `att_hold` in the same way. No other byte uses them.
- R6: A count input of 0, timing or `busy_limit`, behaves as a count of 1.
- R7: In the clock after the closing byte's hold ends, the block starts watching `rb_n`. Once it has sampled `rb_n`=0, it waits for `rb_n`=1, and `done` is 1 in the clock after that sample, with `timeout`=0.
- R8: If `rb_n` stays 1 for `busy_limit` consecutive watch cycles, `done` and `timeout` are both 1 in the next clock.
- R9: With `ce_sensitive`=1 sampled at start, `ce_n` stays 0 through the whole watch until `done`. With it 0, `ce_n` is 1 from the first watch cycle. `ce_n` is 1 whenever `busy`=0.
- R10: `busy` is 1 from the clock after an accepted start until `done`. A `start` while `busy` is ignored, and input changes after acceptance do not alter the running sequence.
- R11: `done` and `timeout` last one clock, and `busy` is 0 while `done` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Sequence request, accepted when not busy |
| cmd_first | input | 8 | Leading command byte |
| cmd_second | input | 8 | Closing command byte |
| row_col_addr | input | 32 | Four address bytes, lowest byte sent first |
| com_setup | input | CNT_W | General set: setup cycles |
| com_low | input | CNT_W | General set: write-enable low cycles |
| com_hold | input | CNT_W | General set: hold cycles |
| att_setup | input | CNT_W | Closing-command set: setup cycles |
| att_low | input | CNT_W | Closing-command set: write-enable low cycles |
| att_hold | input | CNT_W | Closing-command set: hold cycles |
| busy_limit | input | TMO_W | Watch cycles allowed before timeout |
| ce_sensitive | input | 1 | Keep chip enable low through the watch |
| rb_n | input | 1 | Device ready (1) / busy (0), synchronous to clk |
| ce_n | output | 1 | Chip enable, active low |
| we_n | output | 1 | Write enable, active low |
| cle | output | 1 | Command latch enable |
| ale | output | 1 | Address latch enable |
| dq | output | 8 | Byte driven to the device |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-clock completion pulse |
| timeout | output | 1 | With `done`: ready/busy never went low |

## Verification
Bus outputs follow registered state, so the first setup cycle shows one clock after the edge that samples `start`. Each later phase shows exactly the programmed number of clocks after the one before it. `done` appears one clock after the edge that samples `rb_n` high, or after the last allowed watch cycle. The bench builds, for every operation, a list of the expected output values and the `rb_n` value to drive, one entry per clock. It drives and compares at the falling edge, so every comparison sees the state settled by the preceding rising edge.

// File: rtl/nand_seq_pkg.sv
package nand_seq_pkg;

    localparam int CNT_W   = 4;
    localparam int N_ADDR  = 4;
    localparam int N_BYTES = N_ADDR + 2;
    localparam int IDX_W   = $clog2(N_BYTES);

    typedef struct packed {
        logic [CNT_W-1:0] setup;
        logic [CNT_W-1:0] low;
        logic [CNT_W-1:0] hold;
    } bus_timing_t;

    typedef enum logic [1:0] {
        SUB_SETUP = 2'd0,
        SUB_LOW   = 2'd1,
        SUB_HOLD  = 2'd2
    } sub_e;

    typedef enum logic [1:0] {
        WS_OFF   = 2'd0,
        WS_LOOK  = 2'd1,
        WS_RECOV = 2'd2
    } watch_e;

    function automatic logic [CNT_W-1:0] min_one(input logic [CNT_W-1:0] v);
        return (v == '0) ? CNT_W'(1) : v;
    endfunction

endpackage

// File: rtl/nand_bus_timer.sv
module nand_bus_timer
    import nand_seq_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        launch,
    input  bus_timing_t tm,
    output logic        active,
    output logic        we_low,
    output logic        final_cycle
);

    typedef struct packed {
        logic             active;
        sub_e             sub;
        logic [CNT_W-1:0] cnt;
    } timer_t;

    timer_t st_d, st_q;
    logic [CNT_W-1:0] lim;
    logic             last_in_sub;

    always_comb begin
        unique case (st_q.sub)
            SUB_SETUP: lim = min_one(tm.setup);
            SUB_LOW:   lim = min_one(tm.low);
            default:   lim = min_one(tm.hold);
        endcase
        last_in_sub = (st_q.cnt == lim - CNT_W'(1));
        final_cycle = st_q.active && (st_q.sub == SUB_HOLD) && last_in_sub;

        st_d = st_q;
        if (launch) begin
            st_d.active = 1'b1;
            st_d.sub    = SUB_SETUP;
            st_d.cnt    = '0;
        end else if (st_q.active) begin
            if (last_in_sub) begin
                st_d.cnt = '0;
                unique case (st_q.sub)
                    SUB_SETUP: st_d.sub    = SUB_LOW;
                    SUB_LOW:   st_d.sub    = SUB_HOLD;
                    default:   st_d.active = 1'b0;
                endcase
            end else begin
                st_d.cnt = st_q.cnt + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{active: 1'b0, sub: SUB_SETUP, cnt: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign active = st_q.active;
    assign we_low = st_q.active && (st_q.sub == SUB_LOW);

    // R4 / R6: the phase counter never passes its effective limit
    a_r4_cnt_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.active |-> (st_q.cnt < lim));

    // R4: write enable low phase is always followed by the hold phase
    a_r4_low_then_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (we_low && last_in_sub && !launch) |=> (st_q.active && st_q.sub == SUB_HOLD));

endmodule

// File: rtl/nand_rb_watch.sv
module nand_rb_watch
    import nand_seq_pkg::*;
#(
    parameter int TMO_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             arm,
    input  logic             rb_n,
    input  logic [TMO_W-1:0] limit,
    output logic             active,
    output logic             done,
    output logic             timeout
);

    typedef struct packed {
        watch_e           st;
        logic [TMO_W-1:0] cnt;
        logic             done;
        logic             to;
    } watch_t;

    watch_t w_d, w_q;
    logic [TMO_W-1:0] lim_eff;

    always_comb begin
        lim_eff = (limit == '0) ? TMO_W'(1) : limit;
        w_d      = w_q;
        w_d.done = 1'b0;
        w_d.to   = 1'b0;
        unique case (w_q.st)
            WS_OFF: begin
                if (arm) begin
                    w_d.st  = WS_LOOK;
                    w_d.cnt = '0;
                end
            end
            WS_LOOK: begin
                if (!rb_n) begin
                    w_d.st = WS_RECOV;
                end else if (w_q.cnt == lim_eff - TMO_W'(1)) begin
                    w_d.st   = WS_OFF;
                    w_d.done = 1'b1;
                    w_d.to   = 1'b1;
                end else begin
                    w_d.cnt = w_q.cnt + TMO_W'(1);
                end
            end
            default: begin
                if (rb_n) begin
                    w_d.st   = WS_OFF;
                    w_d.done = 1'b1;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            w_q <= '{st: WS_OFF, cnt: '0, done: 1'b0, to: 1'b0};
        end else begin
            w_q <= w_d;
        end
    end

    assign active  = (w_q.st != WS_OFF);
    assign done    = w_q.done;
    assign timeout = w_q.to;

    // R8: timeout only ever reported together with completion
    a_r8_timeout_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        w_q.to |-> w_q.done);

    // R11: completion is a single-clock pulse
    a_r11_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        w_q.done |=> !w_q.done);

    // R7: recovery ends only on a sampled ready level
    a_r7_recov_exit_on_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (w_q.st == WS_RECOV && !rb_n) |=> (w_q.st == WS_RECOV));

endmodule

// File: rtl/nand_seq_ctrl.sv
module nand_seq_ctrl
    import nand_seq_pkg::*;
#(
    parameter int TMO_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [7:0]       cmd_first,
    input  logic [7:0]       cmd_second,
    input  logic [31:0]      row_col_addr,
    input  logic [CNT_W-1:0] com_setup,
    input  logic [CNT_W-1:0] com_low,
    input  logic [CNT_W-1:0] com_hold,
    input  logic [CNT_W-1:0] att_setup,
    input  logic [CNT_W-1:0] att_low,
    input  logic [CNT_W-1:0] att_hold,
    input  logic [TMO_W-1:0] busy_limit,
    input  logic             ce_sensitive,
    input  logic             rb_n,
    output logic             ce_n,
    output logic             we_n,
    output logic             cle,
    output logic             ale,
    output logic [7:0]       dq,
    output logic             busy,
    output logic             done,
    output logic             timeout
);

    localparam int LAST_IDX = N_BYTES - 1;

    typedef struct packed {
        logic                       in_bus;
        logic [IDX_W-1:0]           idx;
        logic [N_BYTES-1:0][7:0]    bytes;
        bus_timing_t                com;
        bus_timing_t                att;
        logic                       ce_mode;
        logic [TMO_W-1:0]           lim;
    } seq_t;

    seq_t s_d, s_q;

    logic [N_BYTES-1:0][7:0] in_bytes;
    logic                    accept, launch, arm, on_last;
    logic                    t_active, t_we_low, t_final;
    logic                    w_active;
    bus_timing_t             tm_sel;

    assign in_bytes[0]       = cmd_first;
    assign in_bytes[LAST_IDX] = cmd_second;
    for (genvar k = 0; k < N_ADDR; k++) begin : g_addr_bytes
        assign in_bytes[k+1] = row_col_addr[8*k +: 8];
    end

    always_comb begin
        on_last = (s_q.idx == IDX_W'(LAST_IDX));
        tm_sel  = on_last ? s_q.att : s_q.com;
        accept  = start && !busy;
        launch  = accept || (s_q.in_bus && t_final && !on_last);
        arm     = s_q.in_bus && t_final && on_last;

        s_d = s_q;
        if (accept) begin
            s_d.in_bus  = 1'b1;
            s_d.idx     = '0;
            s_d.bytes   = in_bytes;
            s_d.com     = '{setup: com_setup, low: com_low, hold: com_hold};
            s_d.att     = '{setup: att_setup, low: att_low, hold: att_hold};
            s_d.ce_mode = ce_sensitive;
            s_d.lim     = busy_limit;
        end else if (s_q.in_bus && t_final) begin
            if (on_last) begin
                s_d.in_bus = 1'b0;
            end else begin
                s_d.idx = s_q.idx + IDX_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    nand_bus_timer u_timer (
        .clk         (clk),
        .rst_n       (rst_n),
        .launch      (launch),
        .tm          (tm_sel),
        .active      (t_active),
        .we_low      (t_we_low),
        .final_cycle (t_final)
    );

    nand_rb_watch #(.TMO_W(TMO_W)) u_watch (
        .clk     (clk),
        .rst_n   (rst_n),
        .arm     (arm),
        .rb_n    (rb_n),
        .limit   (s_q.lim),
        .active  (w_active),
        .done    (done),
        .timeout (timeout)
    );

    always_comb begin
        busy = s_q.in_bus || w_active;
        cle  = t_active && ((s_q.idx == '0) || on_last);
        ale  = t_active && (s_q.idx != '0) && !on_last;
        dq   = t_active ? s_q.bytes[s_q.idx] : 8'h00;
        we_n = !t_we_low;
        ce_n = !(t_active || (w_active && s_q.ce_mode));
    end

    // R3: latch enables never overlap
    a_r3_latch_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(cle && ale));

    // R3: a write strobe always belongs to a command or an address byte
    a_r3_we_low_latched: assert property (@(posedge clk) disable iff (!rst_n)
        !we_n |-> ((cle || ale) && !ce_n));

    // R4: the byte timer runs exactly while the sequencer is in its bus phase
    a_r4_timer_tracks_seq: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.in_bus == t_active);

    // R9: chip enable released whenever idle
    a_r9_ce_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> ce_n);

    // R11: completion is reported from the idle state
    a_r11_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R10: a start while busy leaves the byte position unchanged unless the timer steps it
    a_r10_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (start && s_q.in_bus && !t_final) |=> $stable(s_q.idx));

endmodule

// File: tb/nand_seq_ctrl_test.sv
`timescale 1ns/1ps
module nand_seq_ctrl_test;

    localparam int CW  = nand_seq_pkg::CNT_W;
    localparam int TOW = 8;

    localparam int T_R1 = 1, T_R4 = 4, T_R5 = 5, T_R6 = 6, T_R7 = 7,
                   T_R8 = 8, T_R9 = 9, T_R10 = 10, T_R11 = 11;

    typedef struct packed {
        logic       rb;
        logic       st;
        logic       ce_n;
        logic       we_n;
        logic       cle;
        logic       ale;
        logic [7:0] dq;
        logic       busy;
        logic       done;
        logic       to;
        logic [3:0] tag;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [7:0] cmd_first = '0, cmd_second = '0;
    logic [31:0] row_col_addr = '0;
    logic [CW-1:0] com_setup = '0, com_low = '0, com_hold = '0;
    logic [CW-1:0] att_setup = '0, att_low = '0, att_hold = '0;
    logic [TOW-1:0] busy_limit = '0;
    logic ce_sensitive = 1'b0;
    logic rb_n = 1'b1;
    logic ce_n, we_n, cle, ale, busy, done, timeout;
    logic [7:0] dq;

    int checks = 0;
    int fails = 0;
    exp_t q[$];

    always #2.5 clk = ~clk;

    nand_seq_ctrl #(.TMO_W(TOW)) uut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .cmd_first(cmd_first), .cmd_second(cmd_second), .row_col_addr(row_col_addr),
        .com_setup(com_setup), .com_low(com_low), .com_hold(com_hold),
        .att_setup(att_setup), .att_low(att_low), .att_hold(att_hold),
        .busy_limit(busy_limit), .ce_sensitive(ce_sensitive), .rb_n(rb_n),
        .ce_n(ce_n), .we_n(we_n), .cle(cle), .ale(ale), .dq(dq),
        .busy(busy), .done(done), .timeout(timeout)
    );

    function automatic string tname(input int t);
        case (t)
            T_R1:    return "R1";
            T_R4:    return "R4";
            T_R5:    return "R5";
            T_R6:    return "R6";
            T_R7:    return "R7";
            T_R8:    return "R8";
            T_R9:    return "R9";
            T_R10:   return "R10";
            default: return "R11";
        endcase
    endfunction

    function automatic int eff(input int v);
        return (v == 0) ? 1 : v;
    endfunction

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
        end
    endtask

    function automatic exp_t idle_e(input int tag);
        exp_t e;
        e = '0;
        e.rb = 1'b1; e.ce_n = 1'b1; e.we_n = 1'b1; e.tag = 4'(tag);
        return e;
    endfunction

    // One clock: compare outputs set by the previous rising edge, then drive this cycle.
    task automatic step();
        exp_t e;
        @(negedge clk);
        e = (q.size() > 0) ? q.pop_front() : idle_e(T_R10);
        chk("R2", "dq", int'(dq), int'(e.dq));
        chk("R3", "cle", int'(cle), int'(e.cle));
        chk("R3", "ale", int'(ale), int'(e.ale));
        chk(tname(int'(e.tag)), "we_n", int'(we_n), int'(e.we_n));
        chk("R9", "ce_n", int'(ce_n), int'(e.ce_n));
        chk("R10", "busy", int'(busy), int'(e.busy));
        chk(tname(int'(e.tag)), "done", int'(done), int'(e.done));
        chk(tname(int'(e.tag)), "timeout", int'(timeout), int'(e.to));
        rb_n  = e.rb;
        start = e.st;
    endtask

    // Build the expected per-clock list for one sequence.
    // wait_hi: watch cycles with rb_n high before it drops; rec: cycles low; to_case: never drops.
    task automatic run_op(input logic [7:0] c0, input logic [7:0] c1, input logic [31:0] a,
                          input int cs, input int cl, input int ch,
                          input int as, input int al, input int ah,
                          input int lim, input logic mode,
                          input int wait_hi, input int rec, input bit to_case,
                          input int bus_tag, input int poke_at);
        exp_t e;
        logic [7:0] bytes [6];
        int n;
        bytes[0] = c0; bytes[5] = c1;
        for (int k = 0; k < 4; k++) bytes[k+1] = a[8*k +: 8];
        // byte cycles: R2 order, R4 general timing, R5 closing-command timing
        for (int b = 0; b < 6; b++) begin
            int len [3];
            len[0] = eff((b == 5) ? as : cs);
            len[1] = eff((b == 5) ? al : cl);
            len[2] = eff((b == 5) ? ah : ch);
            for (int p = 0; p < 3; p++) begin
                for (int c = 0; c < len[p]; c++) begin
                    e = '0;
                    e.rb = 1'b1; e.ce_n = 1'b0; e.we_n = (p != 1);
                    e.cle = (b == 0 || b == 5); e.ale = (b >= 1 && b <= 4);
                    e.dq = bytes[b]; e.busy = 1'b1;
                    e.tag = 4'((b == 5 && bus_tag == T_R4) ? T_R5 : bus_tag);
                    q.push_back(e);
                end
            end
        end
        // watch phase, R9 chip enable per mode
        e = '0;
        e.ce_n = !mode; e.we_n = 1'b1; e.busy = 1'b1; e.tag = 4'(T_R7);
        if (to_case) begin
            n = eff(lim);
            for (int c = 0; c < n; c++) begin e.rb = 1'b1; e.tag = 4'(T_R8); q.push_back(e); end
        end else begin
            for (int c = 0; c < wait_hi; c++) begin e.rb = 1'b1; q.push_back(e); end
            e.rb = 1'b0; q.push_back(e);
            for (int c = 0; c < rec; c++) q.push_back(e);
            e.rb = 1'b1; q.push_back(e);
        end
        // completion pulse (R7 or R8), then one idle clock (R11)
        e = idle_e(to_case ? T_R8 : T_R7);
        e.done = 1'b1; e.to = to_case;
        q.push_back(e);
        q.push_back(idle_e(T_R11));
        // R10: a start request while busy must not disturb anything
        if (poke_at >= 0 && poke_at < q.size() - 3) q[poke_at].st = 1'b1;

        cmd_first = c0; cmd_second = c1; row_col_addr = a;
        com_setup = CW'(cs); com_low = CW'(cl); com_hold = CW'(ch);
        att_setup = CW'(as); att_low = CW'(al); att_hold = CW'(ah);
        busy_limit = TOW'(lim); ce_sensitive = mode;
        start = 1'b1;
        step();
        // R10: inputs changed after acceptance have no effect
        cmd_first = ~c0; cmd_second = ~c1; row_col_addr = ~a;
        com_setup = '0; att_hold = '0; ce_sensitive = !mode;
        while (q.size() > 0) step();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual hung expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        for (int i = 0; i < 3; i++) begin
            q.push_back(idle_e(T_R1));
            step();
        end
        // R2 R4 R5 R7 R9: short general timing, long closing hold, release mode
        run_op(8'h00, 8'h30, 32'hA1B2C3D4, 1, 1, 1, 1, 1, 3, 8, 1'b0, 2, 3, 1'b0, T_R4, -1);
        // R4 R5 R9 R10: wider counts, chip-enable-sensitive mode, start pokes while busy
        run_op(8'h80, 8'h10, 32'h12345678, 2, 3, 1, 1, 2, 5, 4, 1'b1, 0, 1, 1'b0, T_R4, 7);
        run_op(8'h60, 8'hD0, 32'h00FF00FF, 1, 2, 2, 2, 1, 4, 6, 1'b1, 1, 2, 1'b0, T_R4, 40);
        // R8: timeout, sensitive mode keeps ce_n low through it
        run_op(8'h85, 8'h11, 32'h5A5AA5A5, 1, 1, 2, 1, 1, 6, 5, 1'b1, 0, 0, 1'b1, T_R4, 30);
        // R6: all counts zero behave as one, including the timeout limit
        run_op(8'hFF, 8'hEE, 32'h01020304, 0, 0, 0, 0, 0, 0, 0, 1'b0, 0, 0, 1'b1, T_R6, -1);
        // R7: busy seen on the last allowed watch cycle
        run_op(8'h31, 8'h32, 32'h89ABCDEF, 1, 1, 1, 2, 2, 2, 3, 1'b0, 2, 0, 1'b0, T_R4, -1);
        for (int i = 0; i < 4; i++) step();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule